// File: doc/BRIEF.md
# Dual-Rate Multiplier Error Monitor

This block is an on-chip self-test harness that measures how often a multiplier datapath returns a wrong product when it is pushed to full clock rate. Two pseudo-random sources each produce an operand every cycle. A fast multiplier path gets a new operand pair every cycle and has one cycle to form its product. Two more copies of the multiplier serve as the reference. They take turns: each lane loads a new operand pair every second cycle and holds it for two cycles before its product is taken. The fast product and the reference product for the same operand pair are compared once per cycle. Every disagreement adds one to a wide saturating error counter. A second counter of the same width counts comparisons, so the error rate is the first count divided by the second.

In RTL both paths compute exactly, so a timing failure on the fast path is modelled by a fault-inject input that flips one chosen bit of the fast product. Seeds for both sources are loaded while reset is held. The comparison stays off while the pipelines fill, so the counts measure only real operand pairs.

Top module: `mul_err_monitor`

## Requirements
- R1: Each source is a 48-bit shift register. Every cycle after reset it shifts one place toward its most significant bit and takes into bit 0 the XOR of its bits 47, 46, 20 and 19. Its low 18 bits are the operand in that cycle, shown on `op_a` for the first source and `op_b` for the second.
- R2: While `rst_n` is low, each source loads its seed input at every clock edge. A seed of zero is loaded as the value 1, so a source never holds zero.
- R3: The fast product and the reference product are both the exact 36-bit product of the operand pair. With no fault injection, `err_count` stays at zero for any seeds.
- R4: Counting through cycle n after reset release (cycle 0 is the first), `op_count` in cycle n is n-3 for n ≥ 3 and 0 before that. The pair from cycle k is compared at the end of cycle k+3.
- R5: When `inj_en` is high in cycle c ≥ 1 and `inj_bit` is below 36, bit `inj_bit` of the fast product of the pair from cycle c-1 is inverted. That adds exactly one to `err_count`, seen from cycle c+3 on.
- R6: An `inj_bit` of 36 or more has no effect, even with `inj_en` high.
- R7: Both counters saturate at all ones and then hold that value.
- R8: A low `rst_n` clears both counters to zero at the next clock edge (synchronous, active low).
- R9: `err_count` never exceeds `op_count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| rst_n | input | 1 | Synchronous active-low reset; seeds are loaded while it is low |
| seed_a | input | 48 | Seed for the first operand source |
| seed_b | input | 48 | Seed for the second operand source |
| inj_en | input | 1 | Fault-inject enable for the fast product |
| inj_bit | input | 6 | Index of the fast-product bit to invert |
| op_a | output | 18 | First operand in the current cycle |
| op_b | output | 18 | Second operand in the current cycle |
| err_count | output | 40 | Saturating count of mismatches |
| op_count | output | 40 | Saturating count of comparisons |

## Verification
The assertions take for granted that `rst_n` is held low from time zero for at least one clock edge, and that `inj_en` and `inj_bit` stay constant through each active edge. They also assume that a mismatch can only come from a deliberate fault injection, which holds because both products are exact in RTL. The stimulus changes every input only on the falling clock edge and starts each scenario with a reset of two cycles. It covers zero, all-ones and mixed seeds, and injects fault windows that overlap the fill period and the end of the run. A narrow-counter instance sees the same stimulus, so saturation is reached within a short run.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
  localparam int DEF_LFSR_W = 48;
  localparam int DEF_OP_W   = 18;
  localparam int DEF_CNT_W  = 40;
  // feedback taps at bits 47, 46, 20, 19 (maximal length for 48 bits)
  localparam logic [47:0] DEF_TAPS = 48'hC000_0018_0000;

  // which reference lane takes new operands in the current cycle
  typedef enum logic {LANE_EVEN = 1'b0, LANE_ODD = 1'b1} lane_e;
endpackage

// File: rtl/mrm_lfsr.sv
module mrm_lfsr #(
  parameter int              W    = 48,
  parameter logic [W-1:0]    TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] next_state(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [W-1:0] safe_seed(input logic [W-1:0] s);
    return (s == '0) ? W'(1) : s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) state <= safe_seed(seed);
    else        state <= next_state(state);
  end
endmodule

// File: rtl/mrm_fast_path.sv
module mrm_fast_path #(
  parameter int  OP_W   = 18,
  localparam int PROD_W = 2 * OP_W,
  localparam int IDX_W  = $clog2(PROD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              inj_en,
  input  logic [IDX_W-1:0]  inj_bit,
  output logic [PROD_W-1:0] prod_o,
  output logic              flip_o
);
  function automatic logic [PROD_W-1:0] fault_mask(input logic en, input logic [IDX_W-1:0] idx);
    if (en && (int'(idx) < PROD_W)) return PROD_W'(1) << idx;
    return '0;
  endfunction

  logic [OP_W-1:0]   a_q, b_q;
  logic [PROD_W-1:0] p_q, p_d;
  logic              f_q, f_d;
  logic [PROD_W-1:0] mask;

  assign mask = fault_mask(inj_en, inj_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0;
      p_q <= '0; f_q <= 1'b0;
      p_d <= '0; f_d <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
      p_q <= (PROD_W'(a_q) * PROD_W'(b_q)) ^ mask;
      f_q <= (mask != '0);
      p_d <= p_q;
      f_d <= f_q;
    end
  end

  assign prod_o = p_d;
  assign flip_o = f_d;
endmodule

// File: rtl/mrm_slow_pair.sv
module mrm_slow_pair import mrm_pkg::*; #(
  parameter int  OP_W   = 18,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  lane_e             phase,
  output logic [PROD_W-1:0] prod_o,
  output logic [1:0]        load_o
);
  logic [PROD_W-1:0] lane_prod [2];
  logic [PROD_W-1:0] stab_q;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [OP_W-1:0] sa_q, sb_q;
    assign load_o[ln] = (phase == lane_e'(1'(ln)));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sa_q <= '0;
        sb_q <= '0;
      end else if (load_o[ln]) begin
        sa_q <= a;
        sb_q <= b;
      end
    end
    // operands held two cycles before the stabilize stage samples them
    assign lane_prod[ln] = PROD_W'(sa_q) * PROD_W'(sb_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stab_q <= '0;
    else        stab_q <= (phase == LANE_ODD) ? lane_prod[1] : lane_prod[0];
  end

  assign prod_o = stab_q;
endmodule

// File: rtl/mrm_sat_counter.sv
module mrm_sat_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] sat_add(input logic [W-1:0] v, input logic up);
    return (up && (v != '1)) ? v + W'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= sat_add(count, inc);
  end
endmodule

// File: rtl/mul_err_monitor.sv
module mul_err_monitor import mrm_pkg::*; #(
  parameter int                LFSR_W = DEF_LFSR_W,
  parameter int                OP_W   = DEF_OP_W,
  parameter int                CNT_W  = DEF_CNT_W,
  parameter logic [LFSR_W-1:0] TAPS   = LFSR_W'(DEF_TAPS),
  localparam int               PROD_W = 2 * OP_W,
  localparam int               IDX_W  = $clog2(PROD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] seed_a,
  input  logic [LFSR_W-1:0] seed_b,
  input  logic              inj_en,
  input  logic [IDX_W-1:0]  inj_bit,
  output logic [OP_W-1:0]   op_a,
  output logic [OP_W-1:0]   op_b,
  output logic [CNT_W-1:0]  err_count,
  output logic [CNT_W-1:0]  op_count
);
  // cycles from an operand pair to its comparison edge
  localparam int FILL   = 3;
  localparam int FILL_W = $clog2(FILL + 1);

  logic [LFSR_W-1:0] seeds      [2];
  logic [LFSR_W-1:0] lfsr_state [2];

  assign seeds[0] = seed_a;
  assign seeds[1] = seed_b;

  for (genvar s = 0; s < 2; s++) begin : g_src
    mrm_lfsr #(.W(LFSR_W), .TAPS(TAPS)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .seed  (seeds[s]),
      .state (lfsr_state[s])
    );
  end

  assign op_a = lfsr_state[0][OP_W-1:0];
  assign op_b = lfsr_state[1][OP_W-1:0];

  // alternating lane select
  lane_e phase_q;
  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= LANE_EVEN;
    else        phase_q <= (phase_q == LANE_EVEN) ? LANE_ODD : LANE_EVEN;
  end

  // fill tracking: compare only once real pairs reach the comparator
  logic [FILL_W-1:0] fill_q;
  logic              cmp_en;
  always_ff @(posedge clk) begin
    if (!rst_n)                        fill_q <= '0;
    else if (fill_q != FILL_W'(FILL))  fill_q <= fill_q + FILL_W'(1);
  end
  assign cmp_en = (fill_q == FILL_W'(FILL));

  logic [PROD_W-1:0] fast_prod, slow_prod;
  logic              fast_flip;
  logic [1:0]        slow_load;

  mrm_fast_path #(.OP_W(OP_W)) u_fast (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (op_a),
    .b       (op_b),
    .inj_en  (inj_en),
    .inj_bit (inj_bit),
    .prod_o  (fast_prod),
    .flip_o  (fast_flip)
  );

  mrm_slow_pair #(.OP_W(OP_W)) u_slow (
    .clk    (clk),
    .rst_n  (rst_n),
    .a      (op_a),
    .b      (op_b),
    .phase  (phase_q),
    .prod_o (slow_prod),
    .load_o (slow_load)
  );

  logic mismatch;
  assign mismatch = cmp_en && (fast_prod != slow_prod);

  mrm_sat_counter #(.W(CNT_W)) u_err_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (mismatch),
    .count (err_count)
  );

  mrm_sat_counter #(.W(CNT_W)) u_op_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cmp_en),
    .count (op_count)
  );
endmodule

// File: rtl/mrm_checker.sv
module mrm_checker #(
  parameter int  LFSR_W = 48,
  parameter int  OP_W   = 18,
  parameter int  CNT_W  = 40,
  localparam int PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_en,
  input logic              fast_flip,
  input logic [PROD_W-1:0] fast_prod,
  input logic [PROD_W-1:0] slow_prod,
  input logic [1:0]        slow_load,
  input logic [LFSR_W-1:0] src_a,
  input logic [LFSR_W-1:0] src_b,
  input logic [CNT_W-1:0]  err_count,
  input logic [CNT_W-1:0]  op_count
);
  AST_SRC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a != '0) && (src_b != '0)); // R2

  AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(slow_load)); // R3

  AST_LANE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (slow_load != $past(slow_load))); // R3

  AST_CLEAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !fast_flip) |-> (fast_prod == slow_prod)); // R3

  AST_FLIP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && fast_flip) |-> (fast_prod != slow_prod)); // R5

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> ($stable(op_count) && $stable(err_count))); // R4

  AST_OP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && (op_count != '1)) |=> (op_count == $past(op_count) + CNT_W'(1))); // R4

  AST_ERR_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == '1) |=> (err_count == '1)); // R7

  AST_OP_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_count == '1) |=> (op_count == '1)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> ((err_count == '0) && (op_count == '0))); // R8

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= op_count); // R9
endmodule

bind mul_err_monitor mrm_checker #(
  .LFSR_W (LFSR_W),
  .OP_W   (OP_W),
  .CNT_W  (CNT_W)
) u_mrm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_en    (cmp_en),
  .fast_flip (fast_flip),
  .fast_prod (fast_prod),
  .slow_prod (slow_prod),
  .slow_load (slow_load),
  .src_a     (lfsr_state[0]),
  .src_b     (lfsr_state[1]),
  .err_count (err_count),
  .op_count  (op_count)
);

// File: tb/test_mul_err_monitor.sv
module test_mul_err_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 6;
  localparam int NARROW_W   = 4;

  // stimulus table: seeds, run length, inject window, inject bit
  localparam logic [47:0] T_SEED_A [N_VEC] = '{48'h0000_0000_0001, 48'h1234_5678_9ABC,
      48'hA5A5_0F0F_3C3C, 48'h0F1E_2D3C_4B5A, 48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF};
  localparam logic [47:0] T_SEED_B [N_VEC] = '{48'h0000_0000_0002, 48'hFEDC_BA98_7654,
      48'h5A5A_F0F0_C3C3, 48'h7766_5544_3322, 48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF};
  localparam int T_RUN   [N_VEC] = '{40, 50, 30, 30, 20, 60};
  localparam int T_START [N_VEC] = '{ 0, 10,  0,  5, 15,  2};
  localparam int T_LEN   [N_VEC] = '{ 0,  5,  4,  3,  5, 50};
  localparam int T_BIT   [N_VEC] = '{ 0,  0, 35, 36, 17, 20};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] seed_a = '0, seed_b = '0;
  logic        inj_en = 1'b0;
  logic [5:0]  inj_bit = '0;
  logic [17:0] op_a, op_b, op_a_n, op_b_n;
  logic [39:0] err_count, op_count;
  logic [NARROW_W-1:0] err_n, ops_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_err_monitor i_mul_err_monitor (
    .clk(clk), .rst_n(rst_n), .seed_a(seed_a), .seed_b(seed_b),
    .inj_en(inj_en), .inj_bit(inj_bit), .op_a(op_a), .op_b(op_b),
    .err_count(err_count), .op_count(op_count));

  mul_err_monitor #(.CNT_W(NARROW_W)) i_mul_err_monitor_narrow (
    .clk(clk), .rst_n(rst_n), .seed_a(seed_a), .seed_b(seed_b),
    .inj_en(inj_en), .inj_bit(inj_bit), .op_a(op_a_n), .op_b(op_b_n),
    .err_count(err_n), .op_count(ops_n));

  // source model written from the requirement, bit by bit
  function automatic logic [47:0] src_next(input logic [47:0] s);
    logic fb;
    fb = s[47] ^ s[46] ^ s[20] ^ s[19];
    return {s[46:0], fb};
  endfunction

  function automatic logic [47:0] src_seed(input logic [47:0] s);
    return (s == 48'd0) ? 48'd1 : s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [47:0] sa, input logic [47:0] sb);
    @(negedge clk);
    rst_n  = 1'b0;
    inj_en = 1'b0;
    seed_a = sa;
    seed_b = sb;
    step();
    step();
    chk("R8 reset err_count", 64'(err_count), 64'd0);
    chk("R8 reset op_count", 64'(op_count), 64'd0);
    chk("R2 seed a in reset", 64'(op_a), 64'(src_seed(sa) & 48'h3FFFF));
    chk("R2 seed b in reset", 64'(op_b), 64'(src_seed(sb) & 48'h3FFFF));
    rst_n = 1'b1;
  endtask

  task automatic run_entry(input int k);
    logic [47:0] ma, mb;
    int exp_err, exp_op, run, nmax;
    string tag;
    run = T_RUN[k];
    do_reset(T_SEED_A[k], T_SEED_B[k]);
    ma = src_seed(T_SEED_A[k]);
    mb = src_seed(T_SEED_B[k]);
    exp_err = 0;
    for (int c = 0; c < run; c++) begin
      inj_en  = (c >= T_START[k]) && (c < T_START[k] + T_LEN[k]);
      inj_bit = 6'(T_BIT[k]);
      if (inj_en && c >= 1 && c + 3 <= run && T_BIT[k] < 36) exp_err++;
      chk("R1 op_a sequence", 64'(op_a), 64'(ma[17:0]));
      chk("R1 op_b sequence", 64'(op_b), 64'(mb[17:0]));
      if (c == 3) chk("R4 no count during fill", 64'(op_count), 64'd0);
      if (c == 4) chk("R4 first comparison", 64'(op_count), 64'd1);
      ma = src_next(ma);
      mb = src_next(mb);
      step();
    end
    inj_en = 1'b0;
    exp_op = run - 3;
    if (T_BIT[k] >= 36)    tag = "R6 out-of-range index ignored";
    else if (T_LEN[k] == 0) tag = "R3 clean run has no errors";
    else                    tag = "R5 injected error count";
    chk(tag, 64'(err_count), 64'(exp_err));
    chk("R4 op_count after run", 64'(op_count), 64'(exp_op));
    chk("R9 err within ops", 64'(err_count <= op_count), 64'd1);
    nmax = (1 << NARROW_W) - 1;
    chk("R7 narrow err saturation", 64'(err_n), 64'((exp_err > nmax) ? nmax : exp_err));
    chk("R7 narrow op saturation", 64'(ops_n), 64'((exp_op > nmax) ? nmax : exp_op));
  endtask

  initial begin
    @(negedge clk);
    for (int k = 0; k < N_VEC; k++) run_entry(k);

    // directed: reset in mid-run clears counts that were non-zero
    do_reset(48'h0000_0BAD_F00D, 48'h0000_0000_C0DE);
    inj_bit = 6'd3;
    inj_en  = 1'b1;
    for (int c = 0; c < 12; c++) step();
    inj_en = 1'b0;
    chk("R5 errors before mid-run reset", 64'(err_count), 64'd9);
    rst_n = 1'b0;
    step();
    chk("R8 mid-run reset err_count", 64'(err_count), 64'd0);
    chk("R8 mid-run reset op_count", 64'(op_count), 64'd0);
    rst_n = 1'b1;

    // directed: saturation of the narrow counters holds steady
    for (int c = 0; c < 30; c++) step();
    chk("R7 narrow op held at max", 64'(ops_n), 64'((1 << NARROW_W) - 1));
    step();
    chk("R7 narrow op still at max", 64'(ops_n), 64'((1 << NARROW_W) - 1));
    chk("R3 no errors without injection", 64'(err_count), 64'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule